// File: doc/BRIEF.md
# Memory-Card Command Issue and Response Capture

This block sits between a processor's register interface and an abstract memory-card port. Software loads a 32-bit argument in two 16-bit halves, turns the block on through a control register, and then writes a command word. The accepted command goes out to the card side as one request beat on a valid/ready stream (index plus argument). The card side answers with one reply beat holding a byte count and up to sixteen bytes. The block decodes that reply according to the response type named in the command word. It fills eight 16-bit response registers and emits a one-cycle completion pulse carrying the status bits to be set.

Back-pressure rules: the request beat (`req_valid`) rises the cycle after an accepted command write. It holds, with index and argument unchanged, until a cycle in which `req_ready` is high. Only then does `rsp_ready` rise. A reply is taken in the first cycle with both `rsp_valid` and `rsp_ready` high. `rsp_valid` in any other cycle is ignored. One command is in flight at a time.

Register selects on `wr_sel`: 0 command word, 1 argument bits 15:0, 2 argument bits 31:16, 3 control (bit 11 = enable), 4 option (bit 13 = also check the authentication-sequence error bit). Other selects are ignored. Command word fields: bits 5:0 index, bits 10:8 response type, bit 11 busy. Status bit positions in `done_status`: 0 end of command, 2 stop command, 7 timeout, 12 card busy, 14 card error.

Top module: `sdc_cmd_capture`

## Requirements
- R1: A command write (select 0) is accepted only when the enable bit (control bit 11) is set and no command is in flight. Otherwise it has no effect. An accepted write gives `start_pulse` high for exactly the next cycle and presents the word's bits 5:0 on `req_index`.
- R2: Selects 1 and 2 each replace only their own 16-bit half of the argument. The request carries the argument as it stood before the command-write edge.
- R3: `req_valid` holds, with index and argument stable, until `req_ready` is seen. `rsp_ready` is high only after that handshake and until a reply is taken. `rsp_valid` at any other time is ignored.
- R4: An accepted command write clears all eight response registers to zero in the same edge.
- R5: Response types 1, 3 and 6 need a byte count of at least 4, and type 2 needs at least 16. A shorter reply sets status bit 7 only (no bit 0, 2, 12 or 14) and leaves the response registers at zero.
- R6: A kept reply is packed in byte pairs: byte 2k is the high byte and byte 2k+1 the low byte of response register 7−k. Bytes at positions at or above the byte count read as zero. Register k appears on `rsp_words[16k+15:16k]`.
- R7: A command that does not time out sets status bit 0. When its index is 12, it sets bits 0 and 2 together.
- R8: For type 1, with or without the busy bit, the reply's first four bytes form a big-endian word. Any of bits 31..26, 24..19 or 16 set gives status bit 14. Bit 3 also counts when option bit 13 was set at the command write.
- R9: For type 3, a clear bit 31 of the big-endian reply word sets status bit 12.
- R10: For type 6, only the low 16 bits of the reply word are tested. Bits 15, 14, 13 and 3 give status bit 14.
- R11: Type 0 and the unlisted codes 4, 5 and 7 take any reply, set bit 0 (and bit 2 for index 12), and leave the response registers at zero.
- R12: `done_pulse` is high for exactly the one cycle after the reply is taken, with all set bits on `done_status`. `done_status` is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 16 | Register write data |
| req_valid | output | 1 | Request beat valid |
| req_ready | input | 1 | Card side accepts request |
| req_index | output | 6 | Command index of the request |
| req_arg | output | 32 | Command argument of the request |
| rsp_valid | input | 1 | Reply beat valid |
| rsp_ready | output | 1 | Block accepts reply |
| rsp_len | input | 5 | Reply byte count (0..16) |
| rsp_bytes | input | 128 | Reply bytes, byte i at bits 8i+7:8i |
| rsp_words | output | 128 | Response registers, register k at bits 16k+15:16k |
| start_pulse | output | 1 | One-cycle pulse on accepted command |
| done_pulse | output | 1 | One-cycle pulse on captured reply |
| done_status | output | 16 | Status bits to set, valid with done_pulse |

## Verification
On every cycle, the assertions check several stream and pulse properties. They check that the request beat holds steady under back-pressure and that a completion follows only a cycle in which the block was ready for a reply. They also check that the start and done pulses last one cycle, that the response registers are empty when a command starts, and that timeout and end of command never appear together. The decoding itself can only be shown by the bench's scenarios, which drive replies of chosen length and content. This covers the error masks for each response type, the optional authentication bit, the card-busy flag, the reverse word packing, the zeroing of bytes beyond the count, and the extra bit for index 12.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [1:0] {
    SDC_IDLE = 2'd0,
    SDC_REQ  = 2'd1,
    SDC_WAIT = 2'd2
  } sdc_state_e;

  // register selects
  localparam logic [2:0] SEL_CMD    = 3'd0;
  localparam logic [2:0] SEL_ARG_LO = 3'd1;
  localparam logic [2:0] SEL_ARG_HI = 3'd2;
  localparam logic [2:0] SEL_CTRL   = 3'd3;
  localparam logic [2:0] SEL_OPT    = 3'd4;

  // response type codes
  localparam logic [2:0] RT_SHORT = 3'd1;
  localparam logic [2:0] RT_LONG  = 3'd2;
  localparam logic [2:0] RT_OCR   = 3'd3;
  localparam logic [2:0] RT_ADDR  = 3'd6;

  // status bit positions
  localparam int ST_END       = 0;
  localparam int ST_STOP      = 2;
  localparam int ST_TIMEOUT   = 7;
  localparam int ST_CARD_BUSY = 12;
  localparam int ST_CARD_ERR  = 14;

  localparam logic [5:0]  STOP_INDEX    = 6'd12;
  localparam int          SHORT_BYTES   = 4;
  localparam logic [31:0] CARD_ERR_MASK = 32'hFDF9_0000;
  localparam logic [31:0] AUTH_SEQ_BIT  = 32'h0000_0008;
  localparam logic [31:0] ADDR_ERR_MASK = 32'h0000_E000;

  typedef struct packed {
    logic [5:0] index;
    logic [2:0] rtype;
    logic       ake;
  } sdc_cmd_t;

endpackage

// File: rtl/sdc_host_regs.sv
module sdc_host_regs
  import sdc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [15:0] wr_data,
  output logic [31:0] arg,
  output logic        enable,
  output logic        ake_en
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arg    <= '0;
      enable <= 1'b0;
      ake_en <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_ARG_LO: arg[15:0]  <= wr_data;
        SEL_ARG_HI: arg[31:16] <= wr_data;
        SEL_CTRL:   enable     <= wr_data[11];
        SEL_OPT:    ake_en     <= wr_data[13];
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/sdc_resp_decode.sv
module sdc_resp_decode
  import sdc_pkg::*;
#(
  parameter int BYTES = 16,
  parameter int LEN_W = 5
) (
  input  sdc_cmd_t             cmd,
  input  logic [LEN_W-1:0]     rsp_len,
  input  logic [BYTES*8-1:0]   rsp_bytes,
  output logic [BYTES*8-1:0]   bytes_m,
  output logic [15:0]          set_bits,
  output logic                 keep
);

  // bytes past the count read as zero
  for (genvar b = 0; b < BYTES; b++) begin : g_mask
    assign bytes_m[b*8 +: 8] = (LEN_W'(b) < rsp_len) ? rsp_bytes[b*8 +: 8] : 8'h00;
  end

  logic [31:0]      word;
  logic [LEN_W-1:0] need;
  logic [31:0]      err_mask;
  logic             ocr;
  logic             timeout;

  assign word = {bytes_m[7:0], bytes_m[15:8], bytes_m[23:16], bytes_m[31:24]};

  always_comb begin
    need     = '0;
    err_mask = '0;
    ocr      = 1'b0;
    case (cmd.rtype)
      RT_SHORT: begin
        need     = LEN_W'(SHORT_BYTES);
        err_mask = CARD_ERR_MASK | (cmd.ake ? AUTH_SEQ_BIT : 32'h0);
      end
      RT_LONG: need = LEN_W'(BYTES);
      RT_OCR: begin
        need = LEN_W'(SHORT_BYTES);
        ocr  = 1'b1;
      end
      RT_ADDR: begin
        need     = LEN_W'(SHORT_BYTES);
        err_mask = ADDR_ERR_MASK | AUTH_SEQ_BIT;
      end
      default: ;
    endcase

    timeout  = (need != '0) && (rsp_len < need);
    keep     = (need != '0) && !timeout;

    set_bits               = '0;
    set_bits[ST_TIMEOUT]   = timeout;
    set_bits[ST_END]       = !timeout;
    set_bits[ST_STOP]      = !timeout && (cmd.index == STOP_INDEX);
    set_bits[ST_CARD_ERR]  = !timeout && |(word & err_mask);
    set_bits[ST_CARD_BUSY] = !timeout && ocr && !word[31];
  end

endmodule

// File: rtl/sdc_resp_bank.sv
module sdc_resp_bank #(
  parameter int WORDS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 load,
  input  logic [WORDS*16-1:0]  bytes_in,
  output logic [WORDS*16-1:0]  words
);

  logic [15:0] mem [WORDS];

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    // pair k lands in the register counted from the top
    always_ff @(posedge clk) begin
      if (!rst_n)    mem[WORDS-1-k] <= '0;
      else if (clr)  mem[WORDS-1-k] <= '0;
      else if (load) mem[WORDS-1-k] <= {bytes_in[(2*k)*8 +: 8], bytes_in[(2*k+1)*8 +: 8]};
    end
    assign words[k*16 +: 16] = mem[k];
  end

endmodule

// File: rtl/sdc_cmd_capture.sv
module sdc_cmd_capture
  import sdc_pkg::*;
#(
  parameter int RSP_WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [2:0]               wr_sel,
  input  logic [15:0]              wr_data,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [5:0]               req_index,
  output logic [31:0]              req_arg,
  input  logic                     rsp_valid,
  output logic                     rsp_ready,
  input  logic [$clog2(2*RSP_WORDS+1)-1:0] rsp_len,
  input  logic [RSP_WORDS*16-1:0]  rsp_bytes,
  output logic [RSP_WORDS*16-1:0]  rsp_words,
  output logic                     start_pulse,
  output logic                     done_pulse,
  output logic [15:0]              done_status
);

  localparam int RSP_BYTES = 2 * RSP_WORDS;
  localparam int LEN_W     = $clog2(RSP_BYTES + 1);

  logic [31:0]            arg;
  logic                   enable;
  logic                   ake_en;
  sdc_state_e             state;
  sdc_cmd_t               cmd_q;
  logic [31:0]            arg_q;
  logic [RSP_BYTES*8-1:0] bytes_m;
  logic [15:0]            set_bits;
  logic                   keep;
  logic                   cmd_fire;
  logic                   rsp_fire;

  sdc_host_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .arg     (arg),
    .enable  (enable),
    .ake_en  (ake_en)
  );

  assign cmd_fire = wr_en && (wr_sel == SEL_CMD) && enable && (state == SDC_IDLE);
  assign rsp_fire = (state == SDC_WAIT) && rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= SDC_IDLE;
      cmd_q       <= '0;
      arg_q       <= '0;
      start_pulse <= 1'b0;
      done_pulse  <= 1'b0;
      done_status <= '0;
    end else begin
      start_pulse <= cmd_fire;
      done_pulse  <= rsp_fire;
      done_status <= rsp_fire ? set_bits : '0;
      case (state)
        SDC_IDLE: if (cmd_fire) begin
          state       <= SDC_REQ;
          cmd_q.index <= wr_data[5:0];
          cmd_q.rtype <= wr_data[10:8];
          cmd_q.ake   <= ake_en;
          arg_q       <= arg;
        end
        SDC_REQ:  if (req_ready) state <= SDC_WAIT;
        SDC_WAIT: if (rsp_valid) state <= SDC_IDLE;
        default:  state <= SDC_IDLE;
      endcase
    end
  end

  assign req_valid = (state == SDC_REQ);
  assign rsp_ready = (state == SDC_WAIT);
  assign req_index = cmd_q.index;
  assign req_arg   = arg_q;

  sdc_resp_decode #(.BYTES(RSP_BYTES), .LEN_W(LEN_W)) u_dec (
    .cmd       (cmd_q),
    .rsp_len   (rsp_len),
    .rsp_bytes (rsp_bytes),
    .bytes_m   (bytes_m),
    .set_bits  (set_bits),
    .keep      (keep)
  );

  sdc_resp_bank #(.WORDS(RSP_WORDS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cmd_fire),
    .load     (rsp_fire && keep),
    .bytes_in (bytes_m),
    .words    (rsp_words)
  );

  // R1: start pulse is single and opens a request
  assert_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> req_valid ##1 !start_pulse);

  // R3: request beat holds under back-pressure
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_index) && $stable(req_arg)));

  // R3: completion only after a ready cycle
  assert_rsp_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(rsp_ready));

  // R4: registers empty when a command starts
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (rsp_words == '0));

  // R5: timeout and end of command are exclusive
  assert_timeout_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (done_status[ST_TIMEOUT] ^ done_status[ST_END]));

  // R7: stop bit only with end of command
  assert_stop_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && done_status[ST_STOP]) |-> done_status[ST_END]);

  // R12: status quiet outside the done cycle, pulse single
  assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pulse |-> (done_status == '0));
  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

endmodule

// File: tb/test_sdc_cmd_capture.sv
module test_sdc_cmd_capture;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_sel = '0;
  logic [15:0]  wr_data = '0;
  logic         req_valid, req_ready = 1'b0;
  logic [5:0]   req_index;
  logic [31:0]  req_arg;
  logic         rsp_valid = 1'b0, rsp_ready;
  logic [4:0]   rsp_len = '0;
  logic [127:0] rsp_bytes = '0;
  logic [127:0] rsp_words;
  logic         start_pulse, done_pulse;
  logic [15:0]  done_status;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  sdc_cmd_capture i_sdc_cmd_capture (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_index(req_index), .req_arg(req_arg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_len(rsp_len), .rsp_bytes(rsp_bytes),
    .rsp_words(rsp_words), .start_pulse(start_pulse), .done_pulse(done_pulse),
    .done_status(done_status)
  );

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int          m_st;
  logic [31:0] m_arg, m_carg;
  logic        m_en, m_ake, m_cake;
  logic [5:0]  m_idx;
  logic [2:0]  m_rt;
  logic        m_start, m_done;
  logic [15:0] m_stat;
  logic [15:0] m_rsp [8];

  function automatic int need_of(logic [2:0] rt);
    case (rt)
      3'd1, 3'd3, 3'd6: return 4;
      3'd2: return 16;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int          old;
    int          nd;
    logic [127:0] mb;
    logic [31:0] w;
    if (!rst_n) begin
      m_st = 0; m_arg = 0; m_carg = 0; m_en = 0; m_ake = 0; m_cake = 0;
      m_idx = 0; m_rt = 0; m_start = 0; m_done = 0; m_stat = 0;
      for (int k = 0; k < 8; k++) m_rsp[k] = 0;
    end else begin
      old = m_st;
      m_start = 0; m_done = 0; m_stat = 0;
      if (old == 2 && rsp_valid) begin
        nd = need_of(m_rt);
        mb = rsp_bytes;
        for (int i = 0; i < 16; i++) if (i >= int'(rsp_len)) mb[i*8 +: 8] = 8'h00;
        w = {mb[7:0], mb[15:8], mb[23:16], mb[31:24]};
        if (nd > 0 && int'(rsp_len) < nd) m_stat = 16'h0080;
        else begin
          m_stat = (m_idx == 6'd12) ? 16'h0005 : 16'h0001;
          if (m_rt == 3'd1 && (w & (32'hFDF9_0000 | (m_cake ? 32'h8 : 32'h0))) != 0) m_stat |= 16'h4000;
          if (m_rt == 3'd6 && (w[15:0] & 16'hE008) != 0) m_stat |= 16'h4000;
          if (m_rt == 3'd3 && !w[31]) m_stat |= 16'h1000;
          if (nd > 0) for (int k = 0; k < 8; k++) m_rsp[7-k] = {mb[k*16 +: 8], mb[k*16+8 +: 8]};
        end
        m_done = 1; m_st = 0;
      end else if (old == 1 && req_ready) m_st = 2;
      if (wr_en) begin
        case (wr_sel)
          3'd0: if (m_en && old == 0) begin
            m_idx = wr_data[5:0]; m_rt = wr_data[10:8]; m_cake = m_ake; m_carg = m_arg;
            for (int k = 0; k < 8; k++) m_rsp[k] = 0;
            m_st = 1; m_start = 1;
          end
          3'd1: m_arg[15:0]  = wr_data;
          3'd2: m_arg[31:16] = wr_data;
          3'd3: m_en  = wr_data[11];
          3'd4: m_ake = wr_data[13];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    logic [127:0] pk;
    if (rst_n) begin
      for (int k = 0; k < 8; k++) pk[k*16 +: 16] = m_rsp[k];
      chk("R1 start pulse", start_pulse, m_start);
      chk("R3 request valid", req_valid, m_st == 1);
      chk("R3 reply ready", rsp_ready, m_st == 2);
      if (m_st == 1) begin
        chk("R2 request argument", req_arg, m_carg);
        chk("R1 request index", req_index, m_idx);
      end
      chk("R12 done pulse", done_pulse, m_done);
      chk("R12 done status", done_status, m_stat);
      chk("R6 response words", rsp_words, pk);
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [127:0] b4(logic [7:0] a0, logic [7:0] a1, logic [7:0] a2, logic [7:0] a3);
    return {96'h0, a3, a2, a1, a0};
  endfunction

  task automatic wr(logic [2:0] sel, logic [15:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_cmd(int dly, logic [4:0] len, logic [127:0] by, logic [15:0] exp, string tag);
    rsp_valid = 1'b1; rsp_len = 5'd16; rsp_bytes = '1;   // ignored: not ready
    repeat (dly) @(negedge clk);
    rsp_valid = 1'b0; req_ready = 1'b1;
    do @(negedge clk); while (!rsp_ready);
    req_ready = 1'b0; rsp_valid = 1'b1; rsp_len = len; rsp_bytes = by;
    do @(negedge clk); while (!done_pulse);
    rsp_valid = 1'b0;
    chk(tag, done_status, exp);
    @(negedge clk);
    chk("R12 done lasts one cycle", done_pulse, 1'b0);
  endtask

  task automatic run(logic [15:0] word, int dly, logic [4:0] len, logic [127:0] by, logic [15:0] exp, string tag);
    wr(3'd0, word);
    finish_cmd(dly, len, by, exp, tag);
  endtask

  initial begin
    logic [127:0] seq;
    for (int i = 0; i < 16; i++) seq[i*8 +: 8] = 8'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset status", done_status, 16'h0);
    chk("R6 reset registers", rsp_words, 128'h0);

    // R1: disabled command write ignored
    wr(3'd0, 16'h0111);
    chk("R1 disabled write no start", start_pulse, 1'b0);
    chk("R1 disabled write no request", req_valid, 1'b0);

    wr(3'd3, 16'h0800);
    wr(3'd1, 16'h1234);
    wr(3'd2, 16'hABCD);
    wr(3'd0, 16'h0111);
    chk("R2 argument halves", req_arg, 32'hABCD_1234);
    chk("R1 index field", req_index, 6'd17);
    // R1: second write while in flight ignored
    wr(3'd0, 16'h0119);
    chk("R1 busy write no start", start_pulse, 1'b0);
    chk("R1 busy write index kept", req_index, 6'd17);
    finish_cmd(3, 5'd4, {{12{8'hEE}}, 8'h00, 8'h09, 8'h00, 8'h00}, 16'h0001, "R7 plain success");
    chk("R6 pair order", rsp_words[111:96], 16'h0900);
    chk("R6 beyond count zero", rsp_words[95:0], 96'h0);

    wr(3'd2, 16'h5555);
    wr(3'd0, 16'h0111);
    chk("R2 high half only", req_arg, 32'h5555_1234);
    finish_cmd(0, 5'd4, b4(8'h00, 8'h40, 8'h00, 8'h00), 16'h4001, "R8 illegal command bit");

    run(16'h090C, 1, 5'd4, b4(8'h00, 8'h00, 8'h09, 8'h00), 16'h0005, "R7 index 12 busy type");
    run(16'h010C, 0, 5'd2, b4(8'h00, 8'h00, 8'h09, 8'h00), 16'h0080, "R5 short reply index 12");
    run(16'h0111, 0, 5'd4, b4(8'h00, 8'h00, 8'h00, 8'h08), 16'h0001, "R8 auth bit unchecked");
    wr(3'd4, 16'h2000);
    run(16'h0111, 0, 5'd4, b4(8'h00, 8'h00, 8'h00, 8'h08), 16'h4001, "R8 auth bit checked");

    run(16'h0202, 2, 5'd16, seq, 16'h0001, "R7 long reply");
    chk("R6 first pair top register", rsp_words[127:112], 16'h0001);
    chk("R6 last pair register 0", rsp_words[15:0], 16'h0E0F);
    wr(3'd0, 16'h0202);
    chk("R4 cleared on command", rsp_words, 128'h0);
    finish_cmd(0, 5'd15, seq, 16'h0080, "R5 long reply too short");
    chk("R5 registers stay zero", rsp_words, 128'h0);

    run(16'h0329, 0, 5'd4, b4(8'h80, 8'hFF, 8'h80, 8'h00), 16'h0001, "R9 ready card");
    run(16'h0329, 0, 5'd4, b4(8'h00, 8'hFF, 8'h80, 8'h00), 16'h1001, "R9 busy card");
    run(16'h0329, 0, 5'd3, b4(8'h00, 8'hFF, 8'h80, 8'h00), 16'h0080, "R5 short reply no busy");

    run(16'h0603, 0, 5'd4, b4(8'h12, 8'h34, 8'h20, 8'h00), 16'h4001, "R10 error bit 13");
    run(16'h0603, 0, 5'd4, b4(8'hFF, 8'hFF, 8'h1F, 8'hF0), 16'h0001, "R10 upper half ignored");

    run(16'h0000, 0, 5'd16, seq, 16'h0001, "R11 no response type");
    chk("R11 registers zero", rsp_words, 128'h0);
    run(16'h050C, 0, 5'd0, seq, 16'h0005, "R11 unlisted code index 12");
    chk("R11 unlisted code registers zero", rsp_words, 128'h0);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule